// File: doc/BRIEF.md
# Pipelined Conversion Timing Sequencer

This block produces the control timing for a successive-approximation converter. An optional gain stage can sit in front of the converter. It runs from a clock at twice the converter rate. A toggling phase register divides every converter cycle into a first half and a second half, and each half lasts one fast clock.

A start request comes from a register write strobe or from an event strobe, and it names a channel. At the next converter-cycle boundary the request is placed in a free conversion slot. That slot then emits its strobes in this order:

- gain-stage sample, then gain-stage amplify, when gain is selected;
- the input sample strobe;
- one bit-decision strobe per half cycle, most significant bit first.

Each slot has its own comparator decision input. The slot gathers the decisions into a partial result. When the conversion finishes, the result goes into that channel's result register and the channel's flag is raised.

Several slots run at once, so a new conversion can begin on every converter cycle. A request that finds every slot occupied raises a busy indication and waits. It is never lost.

Top module: `adcseq_top`

## Requirements
- R1: After synchronous reset, the following are all zero: every result register, every flag, every strobe, `ph_o` and `busy_o`.
- R2: Bit-decision timing, counted in converter cycles after the sample cycle's first half:
  - The MSB decision strobe comes in the second half of that sample cycle.
  - After that, two decisions follow per converter cycle, each one half cycle long.
  - The LSB decision falls in the first half of the final cycle.
  - A conversion without gain therefore spans 5 converter cycles in 8-bit mode and 7 in 12-bit mode.
  - `bit_pos_o` gives the weight of the decision: it counts down from 11 (12-bit) or 7 (8-bit) to 0.
- R3: The sample strobe `smp_o` is high for exactly the first half of the first conversion cycle.
- R4: With `gain_i` high at launch, one converter cycle is inserted before the sample cycle. In that cycle:
  - `gsmp_o` is high in the first half;
  - `gamp_o` is high in the second half;
  - every later event moves two fast clocks later.
- R5: The decision given on `cmp_i` during a bit strobe is stored at the bit's weight. With `wide_i` low at launch (8-bit mode), the stored result is right-aligned and bits 11:8 read 0.
- R6: The result register write and the channel flag set happen on the fast clock edge that ends the final cycle, one half cycle after the LSB decision.
- R7: A request becomes pending on the clock edge on which it is seen. It launches on the first later edge that ends a converter cycle (`ph_o` high before that edge). The result:
  - a request seen in a second half (`ph_o`=1) shows its first strobe three fast clocks later;
  - a request seen in a first half (`ph_o`=0) shows it two fast clocks later.
- R8: One conversion may launch at every converter-cycle boundary. It goes into the lowest-numbered free slot, and the lowest-numbered pending channel launches first. While a request is pending and all slots are occupied, `busy_o` is 1. The request launches once a slot frees.
- R9: A channel's flag is cleared by two things:
  - `rd_i` with `rd_ch_i` naming that channel;
  - a one on that channel's bit of `clr_i`.

  A set and a clear on the same edge leave the flag set.
- R10: Further requests for a channel that is already pending merge into a single conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the converter clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Register-write start strobe |
| evt_i | input | 1 | Event start strobe |
| start_ch_i | input | CHW | Channel named by a start strobe |
| gain_i | input | 1 | Gain stage used by the conversion being launched |
| wide_i | input | 1 | 1 selects 12-bit, 0 selects 8-bit for the launching conversion |
| cmp_i | input | NSLOT | Comparator decision per slot, sampled during its bit strobe |
| rd_i | input | 1 | Result read strobe |
| rd_ch_i | input | CHW | Channel being read |
| clr_i | input | NCH | Write-one flag clear per channel |
| ph_o | output | 1 | Converter phase: 0 first half, 1 second half |
| busy_o | output | 1 | Request waiting with all slots occupied |
| gsmp_o | output | NSLOT | Gain-stage sample strobe per slot |
| gamp_o | output | NSLOT | Gain-stage amplify strobe per slot |
| smp_o | output | NSLOT | Converter sample strobe per slot |
| bit_o | output | NSLOT | Bit-decision strobe per slot |
| slot_ch_o | output | NSLOT x CHW | Channel served by each slot |
| bit_pos_o | output | NSLOT x 4 | Weight of the current decision per slot |
| res_o | output | NCH x 12 | Result register per channel |
| irq_o | output | NCH | Conversion-complete flag per channel |

## Verification
Two functions can fall on the same edge: a conversion retiring into a channel, and a read or write-one clear of that same channel's flag. The bench provokes this by holding the read strobe on a channel for the whole of that channel's conversion. It also issues random clears while conversions of mixed width and gain overlap. The behavioural model applies the clear before the set, and it is compared every clock. That means the flag must show high for exactly one fast clock, and the result must hold the new value.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int RESW = 12;
    localparam int POSW = 4;
    localparam int CYCW = 3;

    typedef struct packed {
        logic gain;
        logic wide;
    } mode_t;

    // converter cycles after the sample cycle until the LSB cycle
    function automatic logic [CYCW-1:0] last_cycle(input logic wide);
        return wide ? CYCW'(6) : CYCW'(4);
    endfunction

    // weight of the first decided bit
    function automatic logic [POSW-1:0] top_weight(input logic wide);
        return wide ? POSW'(11) : POSW'(7);
    endfunction

endpackage

// File: rtl/adcseq_slot.sv
module adcseq_slot
    import adcseq_pkg::*;
#(
    parameter int CHW = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ph_i,
    input  logic                launch_i,
    input  logic [CHW-1:0]      l_ch_i,
    input  mode_t               l_mode_i,
    input  logic                cmp_i,
    output logic                busy_o,
    output logic [CHW-1:0]      ch_o,
    output logic                gsmp_o,
    output logic                gamp_o,
    output logic                smp_o,
    output logic                bit_o,
    output logic [POSW-1:0]     pos_o,
    output logic                done_o,
    output logic [RESW-1:0]     res_o
);

    logic            vld;
    logic [CHW-1:0]  ch;
    mode_t           md;
    logic [CYCW-1:0] cyc;
    logic [RESW-1:0] acc;

    logic            in_gain, act;
    logic [CYCW-1:0] u;
    logic [POSW-1:0] n;

    always_comb begin
        in_gain = vld && md.gain && (cyc == '0);
        act     = vld && !in_gain;
        u       = cyc - CYCW'(md.gain);
        gsmp_o  = in_gain && !ph_i;
        gamp_o  = in_gain && ph_i;
        smp_o   = act && (u == '0) && !ph_i;
        done_o  = act && (u == last_cycle(md.wide)) && ph_i;
        bit_o   = act && !smp_o && !done_o && (u <= last_cycle(md.wide));
        if (u == '0)
            n = '0;
        else
            n = {u, 1'b0} - POSW'(1) + POSW'(ph_i);
        pos_o   = bit_o ? (top_weight(md.wide) - n) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
            ch  <= '0;
            md  <= '0;
            cyc <= '0;
            acc <= '0;
        end else if (launch_i) begin
            vld <= 1'b1;
            ch  <= l_ch_i;
            md  <= l_mode_i;
            cyc <= '0;
            acc <= '0;
        end else if (vld) begin
            if (done_o)
                vld <= 1'b0;
            else if (ph_i)
                cyc <= cyc + CYCW'(1);
            if (bit_o && cmp_i)
                acc[pos_o] <= 1'b1;
        end
    end

    assign busy_o = vld;
    assign ch_o   = ch;
    assign res_o  = acc;

endmodule

// File: rtl/adcseq_arb.sv
module adcseq_arb #(
    parameter int NCH   = 4,
    parameter int NSLOT = 4,
    localparam int CHW  = $clog2(NCH),
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ph_i,
    input  logic             req_i,
    input  logic [CHW-1:0]   req_ch_i,
    input  logic [NSLOT-1:0] slot_busy_i,
    output logic [NSLOT-1:0] launch_o,
    output logic [CHW-1:0]   l_ch_o,
    output logic             busy_o
);

    logic [NCH-1:0] pend, clr, set;
    logic [SW-1:0]  fidx;
    logic           any_free, go;

    always_comb begin
        fidx     = '0;
        any_free = 1'b0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (!slot_busy_i[s]) begin
                fidx     = SW'(s);
                any_free = 1'b1;
            end
        end
        l_ch_o = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (pend[c])
                l_ch_o = CHW'(c);
        end
        go       = ph_i && (|pend) && any_free;
        launch_o = '0;
        clr      = '0;
        if (go) begin
            launch_o[fidx] = 1'b1;
            clr[l_ch_o]    = 1'b1;
        end
        set = '0;
        if (req_i)
            set[req_ch_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else
            pend <= (pend & ~clr) | set;
    end

    assign busy_o = (|pend) && !any_free;

endmodule

// File: rtl/adcseq_res.sv
module adcseq_res
    import adcseq_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int NSLOT = 4,
    localparam int CHW  = $clog2(NCH)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NSLOT-1:0]                 done_i,
    input  logic [NSLOT-1:0][CHW-1:0]        dch_i,
    input  logic [NSLOT-1:0][RESW-1:0]       dres_i,
    input  logic                             rd_i,
    input  logic [CHW-1:0]                   rd_ch_i,
    input  logic [NCH-1:0]                   clr_i,
    output logic [NCH-1:0][RESW-1:0]         res_o,
    output logic [NCH-1:0]                   irq_o
);

    logic [NCH-1:0]           setv, clrv;
    logic [NCH-1:0][RESW-1:0] nxt;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            setv[c] = 1'b0;
            nxt[c]  = res_o[c];
            for (int s = 0; s < NSLOT; s++) begin
                if (done_i[s] && dch_i[s] == CHW'(c)) begin
                    setv[c] = 1'b1;
                    nxt[c]  = dres_i[s];
                end
            end
            clrv[c] = clr_i[c] || (rd_i && rd_ch_i == CHW'(c));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o <= '0;
            irq_o <= '0;
        end else begin
            res_o <= nxt;
            irq_o <= setv | (irq_o & ~clrv);
        end
    end

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int NSLOT = 4,
    localparam int CHW  = $clog2(NCH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic                        evt_i,
    input  logic [CHW-1:0]              start_ch_i,
    input  logic                        gain_i,
    input  logic                        wide_i,
    input  logic [NSLOT-1:0]            cmp_i,
    input  logic                        rd_i,
    input  logic [CHW-1:0]              rd_ch_i,
    input  logic [NCH-1:0]              clr_i,
    output logic                        ph_o,
    output logic                        busy_o,
    output logic [NSLOT-1:0]            gsmp_o,
    output logic [NSLOT-1:0]            gamp_o,
    output logic [NSLOT-1:0]            smp_o,
    output logic [NSLOT-1:0]            bit_o,
    output logic [NSLOT-1:0][CHW-1:0]   slot_ch_o,
    output logic [NSLOT-1:0][POSW-1:0]  bit_pos_o,
    output logic [NCH-1:0][RESW-1:0]    res_o,
    output logic [NCH-1:0]              irq_o
);

    logic                        ph;
    logic [NSLOT-1:0]            launch, sbusy, sdone;
    logic [NSLOT-1:0][RESW-1:0]  sres;
    logic [CHW-1:0]              l_ch;
    mode_t                       l_mode;

    // half-cycle phase of the converter clock
    always_ff @(posedge clk) begin
        if (rst)
            ph <= 1'b0;
        else
            ph <= !ph;
    end

    assign ph_o        = ph;
    assign l_mode.gain = gain_i;
    assign l_mode.wide = wide_i;

    adcseq_arb #(.NCH(NCH), .NSLOT(NSLOT)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .ph_i        (ph),
        .req_i       (start_i | evt_i),
        .req_ch_i    (start_ch_i),
        .slot_busy_i (sbusy),
        .launch_o    (launch),
        .l_ch_o      (l_ch),
        .busy_o      (busy_o)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        adcseq_slot #(.CHW(CHW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .ph_i     (ph),
            .launch_i (launch[s]),
            .l_ch_i   (l_ch),
            .l_mode_i (l_mode),
            .cmp_i    (cmp_i[s]),
            .busy_o   (sbusy[s]),
            .ch_o     (slot_ch_o[s]),
            .gsmp_o   (gsmp_o[s]),
            .gamp_o   (gamp_o[s]),
            .smp_o    (smp_o[s]),
            .bit_o    (bit_o[s]),
            .pos_o    (bit_pos_o[s]),
            .done_o   (sdone[s]),
            .res_o    (sres[s])
        );
    end

    adcseq_res #(.NCH(NCH), .NSLOT(NSLOT)) u_res (
        .clk     (clk),
        .rst     (rst),
        .done_i  (sdone),
        .dch_i   (slot_ch_o),
        .dres_i  (sres),
        .rd_i    (rd_i),
        .rd_ch_i (rd_ch_i),
        .clr_i   (clr_i),
        .res_o   (res_o),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
    parameter int NCH   = 4,
    parameter int NSLOT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ph_o,
    input logic             busy_o,
    input logic [NSLOT-1:0] gamp_o,
    input logic [NSLOT-1:0] smp_o,
    input logic [NSLOT-1:0] bit_o,
    input logic [NCH-1:0]   irq_o
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_s
        // sampling begins right after a converter-cycle boundary
        assert_smp_align_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(smp_o[s]) |-> $past(ph_o));
        // the MSB decision follows the sample half
        assert_msb_next_R2: assert property (@(posedge clk) disable iff (rst)
            smp_o[s] |=> bit_o[s]);
        // amplify is followed by the converter sample
        assert_gain_then_smp_R4: assert property (@(posedge clk) disable iff (rst)
            gamp_o[s] |=> smp_o[s]);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_c
        // flags rise only on an edge that ends a converter cycle
        assert_flag_edge_R6: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_o[c]) |-> $past(ph_o));
    end

    // a full pipeline cannot free up in the middle of a converter cycle
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !ph_o) |=> busy_o);

endmodule

bind adcseq_top adcseq_chk #(.NCH(NCH), .NSLOT(NSLOT)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ph_o   (ph_o),
    .busy_o (busy_o),
    .gamp_o (gamp_o),
    .smp_o  (smp_o),
    .bit_o  (bit_o),
    .irq_o  (irq_o)
);

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;

    localparam int NCH   = 4;
    localparam int NSLOT = 4;
    localparam int CHW   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, evt_i = 1'b0, gain_i = 1'b0, wide_i = 1'b0, rd_i = 1'b0;
    logic [CHW-1:0] start_ch_i = '0, rd_ch_i = '0;
    logic [NCH-1:0] clr_i = '0;
    logic [NSLOT-1:0] cmp = '0;
    logic ph_o, busy_o;
    logic [NSLOT-1:0] gsmp_o, gamp_o, smp_o, bit_o;
    logic [NSLOT-1:0][CHW-1:0] slot_ch_o;
    logic [NSLOT-1:0][3:0] bit_pos_o;
    logic [NCH-1:0][11:0] res_o;
    logic [NCH-1:0] irq_o;

    always #4 clk = !clk;

    adcseq_top #(.NCH(NCH), .NSLOT(NSLOT)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .evt_i(evt_i), .start_ch_i(start_ch_i),
        .gain_i(gain_i), .wide_i(wide_i), .cmp_i(cmp), .rd_i(rd_i), .rd_ch_i(rd_ch_i),
        .clr_i(clr_i), .ph_o(ph_o), .busy_o(busy_o), .gsmp_o(gsmp_o), .gamp_o(gamp_o),
        .smp_o(smp_o), .bit_o(bit_o), .slot_ch_o(slot_ch_o), .bit_pos_o(bit_pos_o),
        .res_o(res_o), .irq_o(irq_o)
    );

    int nchk = 0, nfail = 0, ncyc = 0;
    bit fin = 1'b0;
    logic [11:0] code [NCH];
    initial begin
        code[0] = 12'hA5C; code[1] = 12'h3F1; code[2] = 12'hC36; code[3] = 12'h5E9;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, ncyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  mv[NSLOT], mch[NSLOT], mg[NSLOT], mw[NSLOT], mh[NSLOT];
    bit  mfree[NSLOT];
    bit  mpend[NCH], mirq[NCH];
    int  mres[NCH];
    bit  mph;
    int  lc, ls, k;
    bit  anyp, anyf;

    always @(posedge clk) begin
        ncyc++;
        if (rst) begin
            for (int s = 0; s < NSLOT; s++) begin mv[s] = 0; mh[s] = 0; end
            for (int c = 0; c < NCH; c++) begin mpend[c] = 0; mirq[c] = 0; mres[c] = 0; end
            mph = 0;
        end else begin
            for (int s = 0; s < NSLOT; s++) mfree[s] = (mv[s] == 0);
            for (int c = 0; c < NCH; c++)
                if (clr_i[c] || (rd_i && int'(rd_ch_i) == c)) mirq[c] = 0;
            for (int s = 0; s < NSLOT; s++) begin
                if (mv[s] != 0) begin
                    k = mh[s] - 2 * mg[s];
                    if (k == mw[s] + 1) begin
                        mres[mch[s]] = int'(code[mch[s]]) & ((1 << mw[s]) - 1);
                        mirq[mch[s]] = 1;
                        mv[s] = 0;
                    end else begin
                        mh[s]++;
                    end
                end
            end
            anyp = 0; anyf = 0; lc = 0; ls = 0;
            for (int c = NCH - 1; c >= 0; c--) if (mpend[c]) begin anyp = 1; lc = c; end
            for (int s = NSLOT - 1; s >= 0; s--) if (mfree[s]) begin anyf = 1; ls = s; end
            if (mph && anyp && anyf) begin
                mv[ls] = 1; mch[ls] = lc; mg[ls] = int'(gain_i);
                mw[ls] = wide_i ? 12 : 8; mh[ls] = 0; mpend[lc] = 0;
            end
            if (start_i || evt_i) mpend[start_ch_i] = 1;
            mph = !mph;
        end
    end

    // compare every clock, away from the active edge, and drive decisions
    bit eg, ea, es, eb, ebusy, allv;
    int epos;
    always @(negedge clk) begin
        if (rst) begin
            cmp <= '0;
        end else if (!fin) begin
            anyp = 0; allv = 1;
            for (int c = 0; c < NCH; c++) if (mpend[c]) anyp = 1;
            for (int s = 0; s < NSLOT; s++) if (mv[s] == 0) allv = 0;
            ebusy = anyp && allv;
            chk(busy_o == ebusy, "R8 busy", busy_o, ebusy);
            chk(ph_o == mph, "R7 phase", ph_o, mph);
            for (int s = 0; s < NSLOT; s++) begin
                eg = 0; ea = 0; es = 0; eb = 0; epos = 0;
                if (mv[s] != 0) begin
                    if (mh[s] < 2 * mg[s]) begin
                        eg = (mh[s] == 0); ea = (mh[s] == 1);
                    end else begin
                        k = mh[s] - 2 * mg[s];
                        es = (k == 0);
                        eb = (k >= 1) && (k <= mw[s]);
                        epos = mw[s] - k;
                    end
                end
                chk(gsmp_o[s] == eg && gamp_o[s] == ea, "R4 gain strobes",
                    {gsmp_o[s], gamp_o[s]}, {eg, ea});
                chk(smp_o[s] == es, "R3 sample strobe", smp_o[s], es);
                chk(bit_o[s] == eb, "R2 bit strobe", bit_o[s], eb);
                if (eb) begin
                    chk(int'(bit_pos_o[s]) == epos, "R2 bit weight", bit_pos_o[s], epos);
                    cmp[s] <= code[mch[s]][epos];
                end else begin
                    cmp[s] <= 1'b0;
                end
            end
            for (int c = 0; c < NCH; c++) begin
                chk(irq_o[c] == mirq[c], "R6 flag", irq_o[c], mirq[c]);
                chk(int'(res_o[c]) == mres[c], "R5 result", res_o[c], mres[c]);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic align(input bit want_ph);
        @(negedge clk);
        while (ph_o != want_ph) @(negedge clk);
    endtask

    int first, cnt;
    logic [15:0] lf;
    bit prev;

    initial begin
        idle(4);
        chk(busy_o == 0 && irq_o == '0 && res_o == '0, "R1 reset outputs", irq_o, 0);
        chk(smp_o == '0 && bit_o == '0 && gsmp_o == '0 && gamp_o == '0 && ph_o == 0,
            "R1 reset strobes", smp_o, 0);
        rst = 1'b0;
        idle(3);

        // R7: request seen in second half -> sample three clocks later (12-bit, no gain)
        align(1'b1);
        start_i = 1; start_ch_i = 0; wide_i = 1; gain_i = 0;
        first = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            start_i = 0;
            if (smp_o[0] && first == 0) first = i;
        end
        chk(first == 3, "R7 late request latency", first, 3);
        idle(20);
        chk(res_o[0] == code[0], "R5 12-bit result", res_o[0], code[0]);
        chk(irq_o[0] == 1, "R6 flag set", irq_o[0], 1);
        rd_i = 1; rd_ch_i = 0;
        @(negedge clk); rd_i = 0;
        chk(irq_o[0] == 0, "R9 read clears flag", irq_o[0], 0);

        // R4/R7: event in first half, 8-bit with gain
        align(1'b0);
        evt_i = 1; start_ch_i = 1; wide_i = 0; gain_i = 1;
        first = 0; cnt = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            evt_i = 0;
            if (gsmp_o[0] && first == 0) first = i;
            if (smp_o[0] && cnt == 0) cnt = i;
        end
        chk(first == 2, "R7 early request latency", first, 2);
        chk(cnt == 4, "R4 gain adds one converter cycle", cnt, 4);
        idle(16);
        chk(res_o[1] == {4'h0, code[1][7:0]}, "R5 8-bit right-aligned", res_o[1], code[1][7:0]);
        clr_i = 4'b0010;
        @(negedge clk); clr_i = 0;
        chk(irq_o[1] == 0, "R9 write-one clears flag", irq_o[1], 0);

        // R8: fill every slot, then one more request
        wide_i = 1; gain_i = 1;
        for (int c = 0; c < NCH; c++) begin
            start_i = 1; start_ch_i = CHW'(c);
            @(negedge clk);
        end
        start_ch_i = 0;
        @(negedge clk); start_i = 0;
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (busy_o) cnt++;
        end
        chk(cnt > 0, "R8 busy seen when full", cnt, 1);
        idle(30);
        clr_i = '1; @(negedge clk); clr_i = 0;

        // R10: two requests for one channel before launch merge
        align(1'b1);
        start_i = 1; start_ch_i = 2; wide_i = 0; gain_i = 0;
        idle(2); start_i = 0;
        cnt = 0; prev = 0;
        for (int i = 0; i < 30; i++) begin
            if ((|smp_o) && !prev) cnt++;
            prev = |smp_o;
            @(negedge clk);
        end
        chk(cnt == 1, "R10 merged requests", cnt, 1);

        // R9: clear held on the retiring channel; set wins for one clock
        rd_i = 1; rd_ch_i = 3;
        evt_i = 1; start_ch_i = 3; wide_i = 0; gain_i = 0;
        @(negedge clk); evt_i = 0;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (irq_o[3]) cnt++;
        end
        chk(cnt == 1, "R9 set beats clear", cnt, 1);
        chk(res_o[3] == {4'h0, code[3][7:0]}, "R5 result on collision", res_o[3], code[3][7:0]);
        rd_i = 0;

        // mixed traffic checked by the model every clock
        lf = 16'hACE1;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            start_i    = lf[0] & lf[3];
            evt_i      = lf[5] & lf[7] & lf[1];
            start_ch_i = lf[9:8];
            gain_i     = lf[11];
            wide_i     = lf[12];
            rd_i       = lf[2] & lf[6] & lf[14];
            rd_ch_i    = lf[4:3];
            clr_i      = (lf[13] & lf[10]) ? lf[15:12] : '0;
        end
        start_i = 0; evt_i = 0; rd_i = 0; clr_i = 0;
        idle(40);
        fin = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    always @(posedge clk) begin
        if (ncyc > 100000 && !fin) begin
            fin = 1'b1;
            nchk++; nfail++;
            $display("FAIL watchdog: all requirements, actual=hung expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule